// File: doc/BRIEF.md
# Masked Interrupt Register Group

This block holds the interrupt state of one group of up to 32 event sources. Four registers sit behind a small register bus. The bus has a byte address, a write strobe, write data, and combinational read data. The four registers are a raw status view, a mask, a sticky identity register of latched events, and an enable.

Each cycle, the block samples the 32-bit event input.

- An event bit whose mask bit is clear sets its identity bit.
- An event bit whose mask bit is set is thrown away. Clearing the mask bit later does not bring it back.

Software acknowledges latched events by writing ones to the identity register. The identity register ANDed with the enable register forms a pending vector. That vector feeds an aggregator one level up.

Top module: `intr_reg_group`

## Requirements
- R1: Register byte offsets within the group are fixed: status 0x0, mask 0x4, identity 0x8, enable 0xC. A read of any other offset returns zero.
- R2: After reset, the mask reads 0xFFFFFFFF, the identity reads 0, the enable reads 0, and the pending output is 0.
- R3: An event bit that is high in a cycle while its mask bit is 0 sets the identity bit at that clock edge. The bit stays set until software clears it.
- R4: An event bit that is high while its mask bit is 1 leaves the identity bit unchanged. A later write of 0 to that mask bit does not make the dropped event appear.
- R5: A write to the identity offset clears every identity bit written as 1 and leaves the bits written as 0 unchanged.
- R6: When an event sets an identity bit in the same cycle that a write clears it, the bit ends up set.
- R7: Several event bits in one cycle are all latched, each gated only by its own mask bit.
- R8: The mask and enable registers take the full 32-bit written value and read it back unchanged.
- R9: The pending output equals identity AND enable. It reflects a new event, an identity write or an enable write from the cycle after that edge.
- R10: A read of the status offset returns the live event input. A write to the status offset changes no register.
- R11: A write to an offset other than mask, identity or enable changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (4) | Byte offset within the group |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| evt_in | input | DATA_W (32) | Raw event vector, one bit per source |
| pend_out | output | DATA_W (32) | Identity AND enable, to the aggregator |

## Verification
Two functions can fall in the same clock edge and change the same identity bit:

- a new unmasked event that sets the bit, and
- a software write that clears it.

The bench drives both at once. It raises an event on one bit in the cycle that an identity write carries a one on that same bit and on several other latched bits. The judgement is that the targeted bit survives while the other written bits clear. A second overlap is also covered: a mask write and an event in the same cycle. In that case the event is gated by the mask value held before the edge.

// File: rtl/intr_grp_pkg.sv
package intr_grp_pkg;

   // Register offsets; the aggregator decodes these, so they are fixed.
   localparam logic [3:0] OFS_STATUS = 4'h0;
   localparam logic [3:0] OFS_MASK   = 4'h4;
   localparam logic [3:0] OFS_IDENT  = 4'h8;
   localparam logic [3:0] OFS_ENABLE = 4'hC;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_IDENT  = 2'd2,
      SEL_ENABLE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic     hit;
      reg_sel_e sel;
   } reg_dec_t;

endpackage

// File: rtl/intr_addr_decode.sv
module intr_addr_decode
   import intr_grp_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_dec_t          dec_o
);

   localparam int HI_W = ADDR_W - 4;

   logic          upper_zero;
   logic [3:0]    low_ofs;

   generate
      if (HI_W > 0) begin : g_hi
         assign upper_zero = (addr_i[ADDR_W-1:4] == '0);
      end else begin : g_nohi
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign low_ofs = addr_i[3:0];

   always_comb begin
      dec_o.hit = 1'b0;
      dec_o.sel = SEL_STATUS;
      if (upper_zero) begin
         unique case (low_ofs)
            OFS_STATUS: begin dec_o.hit = 1'b1; dec_o.sel = SEL_STATUS; end
            OFS_MASK:   begin dec_o.hit = 1'b1; dec_o.sel = SEL_MASK;   end
            OFS_IDENT:  begin dec_o.hit = 1'b1; dec_o.sel = SEL_IDENT;  end
            OFS_ENABLE: begin dec_o.hit = 1'b1; dec_o.sel = SEL_ENABLE; end
            default:    begin dec_o.hit = 1'b0; dec_o.sel = SEL_STATUS; end
         endcase
      end
   end

endmodule

// File: rtl/intr_ctrl_regs.sv
module intr_ctrl_regs #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we_i,
   input  logic              en_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] en_o
);

   localparam logic [DATA_W-1:0] MASK_RST = '1;
   localparam logic [DATA_W-1:0] EN_RST   = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o <= MASK_RST;
      end else if (mask_we_i) begin
         mask_o <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o <= EN_RST;
      end else if (en_we_i) begin
         en_o <= wdata_i;
      end
   end

   // R8
   mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> (mask_o == $past(wdata_i)));

   // R8
   en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_we_i |=> (en_o == $past(wdata_i)));

endmodule

// File: rtl/intr_ident_bank.sv
module intr_ident_bank #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic              clr_we_i,
   input  logic [DATA_W-1:0] clr_data_i,
   output logic [DATA_W-1:0] ident_o
);

   logic [DATA_W-1:0] set_v;
   logic [DATA_W-1:0] clr_v;

   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_cell
         assign set_v[b] = evt_i[b] & ~mask_i[b];
         assign clr_v[b] = clr_we_i & clr_data_i[b];

         // Set has priority over a same-cycle clear.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ident_o[b] <= 1'b0;
            end else if (set_v[b]) begin
               ident_o[b] <= 1'b1;
            end else if (clr_v[b]) begin
               ident_o[b] <= 1'b0;
            end
         end
      end
   endgenerate

   // R3 R7
   evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt_i & ~mask_i) & ~ident_o) == '0));

   // R4
   masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((ident_o & ~$past(ident_o)) & ~$past(evt_i & ~mask_i)) == '0));

   // R5 R6
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((ident_o & $past(clr_data_i & ~(evt_i & ~mask_i))) == '0));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(ident_o) & ~ident_o & ~$past({DATA_W{clr_we_i}} & clr_data_i)) == '0));

endmodule

// File: rtl/intr_reg_group.sv
module intr_reg_group
   import intr_grp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] evt_in,
   output logic [DATA_W-1:0] pend_out
);

   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
         $error("intr_reg_group: DATA_W must lie in 1..32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("intr_reg_group: ADDR_W must be at least 4");
      end
   endgenerate

   reg_dec_t          dec;
   logic              we_mask;
   logic              we_en;
   logic              we_ident;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] ident_q;

   intr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i (reg_addr),
      .dec_o  (dec)
   );

   assign we_mask  = reg_wr & dec.hit & (dec.sel == SEL_MASK);
   assign we_en    = reg_wr & dec.hit & (dec.sel == SEL_ENABLE);
   assign we_ident = reg_wr & dec.hit & (dec.sel == SEL_IDENT);

   intr_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_we_i (we_mask),
      .en_we_i   (we_en),
      .wdata_i   (reg_wdata),
      .mask_o    (mask_q),
      .en_o      (en_q)
   );

   intr_ident_bank #(.DATA_W(DATA_W)) u_ident (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_in),
      .mask_i     (mask_q),
      .clr_we_i   (we_ident),
      .clr_data_i (reg_wdata),
      .ident_o    (ident_q)
   );

   assign pend_out = ident_q & en_q;

   always_comb begin
      reg_rdata = '0;
      if (dec.hit) begin
         unique case (dec.sel)
            SEL_STATUS: reg_rdata = evt_in;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_IDENT:  reg_rdata = ident_q;
            SEL_ENABLE: reg_rdata = en_q;
            default:    reg_rdata = '0;
         endcase
      end
   end

   // R10 R11
   no_stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !(we_mask || we_en || we_ident)) |=>
         ((mask_q == $past(mask_q)) && (en_q == $past(en_q))));

   // R9
   pend_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_out & ~reg_rdata) == '0) || !(dec.hit && dec.sel == SEL_IDENT));

endmodule

// File: tb/intr_reg_group_tb.sv
module intr_reg_group_tb;

   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [DW-1:0] evt_in = '0;
   logic [DW-1:0] pend_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   intr_reg_group #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_in    (evt_in),
      .pend_out  (pend_out)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [DW-1:0] v);
      @(negedge clk);
      evt_in = v;
      @(negedge clk);
      evt_in = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] r;
      logic [DW-1:0] exp_id;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset values
      rd(4'h4, r); check("R2 mask", r, '1);
      rd(4'h8, r); check("R2 ident", r, '0);
      rd(4'hC, r); check("R2 enable", r, '0);
      check("R2 pend", pend_out, '0);

      // R8 full-value read/write with several patterns
      wr(4'h4, 32'hA5C3_0F96); rd(4'h4, r); check("R8 mask", r, 32'hA5C3_0F96);
      wr(4'hC, 32'h5A3C_F069); rd(4'hC, r); check("R8 enable", r, 32'h5A3C_F069);
      wr(4'h4, '0); rd(4'h4, r); check("R8 mask zero", r, '0);
      wr(4'hC, '1); rd(4'hC, r); check("R8 enable ones", r, '1);

      // R3 R5 R9 per-bit sweep
      for (int b = 0; b < DW; b++) begin
         pulse(32'h1 << b);
         rd(4'h8, r); check("R3 latch", r, 32'h1 << b);
         check("R9 pend after event", pend_out, 32'h1 << b);
         wr(4'h8, 32'h1 << b);
         rd(4'h8, r); check("R5 clear", r, '0);
      end

      // R7 R4 mixed mask, then unmask
      wr(4'h4, 32'h0000_FFFF);
      pulse('1);
      rd(4'h8, r); check("R7 multi latch", r, 32'hFFFF_0000);
      wr(4'h4, '0);
      rd(4'h8, r); check("R4 no reappear", r, 32'hFFFF_0000);

      // R5 partial clear
      wr(4'h8, 32'h0F0F_0000);
      rd(4'h8, r); check("R5 partial", r, 32'hF0F0_0000);

      // R9 enable subset
      wr(4'hC, 32'h3000_0000);
      check("R9 pend enable", pend_out, 32'h3000_0000);

      // R6 set wins over same-cycle clear
      @(negedge clk);
      reg_addr = 4'h8; reg_wdata = 32'hF0F0_0008; reg_wr = 1'b1; evt_in = 32'h8;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; evt_in = '0;
      rd(4'h8, r); check("R6 set wins", r, 32'h0000_0008);

      // mask write and event in same cycle: old mask (0) gates
      @(negedge clk);
      reg_addr = 4'h4; reg_wdata = '1; reg_wr = 1'b1; evt_in = 32'h10;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; evt_in = '0;
      exp_id = 32'h18;
      rd(4'h8, r); check("R4 old mask gates", r, exp_id);

      // R10 status live and write-ignored
      @(negedge clk);
      evt_in = 32'hA5A5_5A5A;
      rd(4'h0, r); check("R10 status live", r, 32'hA5A5_5A5A);
      wr(4'h0, 32'h0000_0000);
      evt_in = '0;
      rd(4'h4, r); check("R10 mask kept", r, '1);
      rd(4'h8, r); check("R10 ident kept", r, exp_id);

      // R11 R1 unmapped offsets
      for (int a = 0; a < 16; a++) begin
         if (a % 4 != 0) begin
            wr(a[AW-1:0], 32'h0);
            rd(a[AW-1:0], r); check("R1 unmapped read", r, '0);
         end
      end
      rd(4'h4, r); check("R11 mask kept", r, '1);
      rd(4'hC, r); check("R11 enable kept", r, 32'h3000_0000);
      rd(4'h8, r); check("R11 ident kept", r, exp_id);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule